// File: doc/BRIEF.md
# Serial Command/Data Byte Receiver

This block is the write-only serial host port of a display controller. A host drives an active-low chip select, a serial clock, a serial data line and a data/command select line. While chip select is low, data bits are shifted in on rising serial-clock edges, most significant bit first. On the rising edge that completes each byte, the data/command line is sampled, and that sample alone decides where the byte goes. The level of the line on any other edge does not matter, so one chip-select period can mix command and data bytes.

Each completed byte and its destination flag cross into the system clock domain through a toggle handshake. There the block issues a single-cycle write strobe on either the command port or the display-RAM port, and presents the byte on a shared data bus. The link has no flow control, so the sink has no ready signal and must accept every strobe. The host must leave at least four system-clock cycles between the completing edges of two successive bytes. Raising chip select part-way through a byte drops the bits gathered so far.

Top module: `spi_cmd_rx`

## Requirements
- R1: During and after reset, with no serial traffic, `cmd_wr` and `ram_wr` are 0 and `wr_data` is 0x00.
- R2: The bits of each byte arrive on `sdi` at rising `sck` edges with bit 7 first. The byte on `wr_data` during its write strobe equals those eight bits.
- R3: The `dc` level at the eighth rising edge of a byte sets its destination. A value of 1 pulses `ram_wr` and a value of 0 pulses `cmd_wr`.
- R4: The `dc` level at the first seven rising edges of a byte has no effect on its destination.
- R5: Several bytes can be sent back to back within one chip-select-low period. The bit count wraps after every eighth edge.
- R6: Taking `cs_n` high before a byte is complete discards the partial bits. No strobe results, and the next byte starts at the first edge after `cs_n` falls again.
- R7: Rising `sck` edges while `cs_n` is high produce no write and do not shift the byte alignment.
- R8: Each completed byte gives exactly one strobe, one cycle long. `cmd_wr` and `ram_wr` are never high together, and `wr_data` changes only together with a strobe.
- R9: The strobe for a byte is high in the third system-clock cycle after the cycle in which its eighth `sck` edge occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, data taken on rising edge |
| sdi | input | 1 | Serial data in, bit 7 first |
| dc | input | 1 | Data/command select: 1 means display RAM, 0 means command |
| cmd_wr | output | 1 | One-cycle write strobe to the command register port |
| ram_wr | output | 1 | One-cycle write strobe to the display-RAM data port |
| wr_data | output | 8 | Byte carried with the current strobe, held until the next one |

## Verification
Every serial edge in the bench is placed on a falling system-clock edge. This fixes the strobe at the third falling edge after the completing `sck` rise: two edges pass through the synchronizer and one passes through the output register. After each completing edge, the bench counts falling edges, takes the first strobe it sees, and checks both that it came on exactly the third edge and that its byte and port are right. A free-running monitor counts every strobe and every strobe that lasts more than one cycle. This catches the missing or extra writes that the partial-byte and chip-select-high cases must not produce.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int SYNC_DEPTH = 2;

  typedef enum logic {
    DEST_CMD = 1'b0,
    DEST_RAM = 1'b1
  } dest_e;
endpackage

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter
  import spi_rx_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              dc,
  output logic [DATA_W-1:0] cap_byte,
  output dest_e             cap_dest,
  output logic              cap_tgl
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] next_byte;

  assign next_byte = {shreg[DATA_W-2:0], sdi};

  // Chip select high holds the counter at zero, which drops partial bytes
  always_ff @(posedge sck or posedge cs_n) begin
    if (cs_n) bit_cnt <= '0;
    else if (bit_cnt == LAST_BIT) bit_cnt <= '0;
    else bit_cnt <= bit_cnt + 1'b1;
  end

  always_ff @(posedge sck) begin
    shreg <= next_byte;
  end

  // The counter only reaches LAST_BIT while selected, so dc matters only on the final edge
  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      cap_byte <= '0;
      cap_dest <= DEST_CMD;
      cap_tgl  <= 1'b0;
    end else if (bit_cnt == LAST_BIT) begin
      cap_byte <= next_byte;
      cap_dest <= dest_e'(dc);
      cap_tgl  <= ~cap_tgl;
    end
  end
endmodule

// File: rtl/spi_rx_toggle_sync.sv
module spi_rx_toggle_sync
  import spi_rx_pkg::*;
#(
  parameter int STAGES = SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic evt
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else chain <= {chain[STAGES-1:0], tgl_in};
  end

  assign evt = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/spi_rx_router.sv
module spi_rx_router
  import spi_rx_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [DATA_W-1:0] byte_in,
  input  dest_e             dest_in,
  output logic              cmd_wr,
  output logic              ram_wr,
  output logic [DATA_W-1:0] wr_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_wr  <= 1'b0;
      ram_wr  <= 1'b0;
      wr_data <= '0;
    end else begin
      cmd_wr <= evt && (dest_in == DEST_CMD);
      ram_wr <= evt && (dest_in == DEST_RAM);
      if (evt) wr_data <= byte_in;
    end
  end
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
  import spi_rx_pkg::*;
#(
  parameter int DATA_W      = BYTE_W,
  parameter int SYNC_STAGES = SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              dc,
  output logic              cmd_wr,
  output logic              ram_wr,
  output logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] cap_byte;
  dest_e             cap_dest;
  logic              cap_tgl;
  logic              byte_evt;

  spi_rx_shifter #(.DATA_W(DATA_W)) u_shift (
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sck      (sck),
    .sdi      (sdi),
    .dc       (dc),
    .cap_byte (cap_byte),
    .cap_dest (cap_dest),
    .cap_tgl  (cap_tgl)
  );

  spi_rx_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .tgl_in (cap_tgl),
    .evt    (byte_evt)
  );

  spi_rx_router #(.DATA_W(DATA_W)) u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (byte_evt),
    .byte_in (cap_byte),
    .dest_in (cap_dest),
    .cmd_wr  (cmd_wr),
    .ram_wr  (ram_wr),
    .wr_data (wr_data)
  );
endmodule

// File: rtl/spi_cmd_rx_checker.sv
module spi_cmd_rx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_wr,
  input logic              ram_wr,
  input logic [DATA_W-1:0] wr_data,
  input logic              byte_evt
);
  AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_wr && ram_wr)); // R8
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> !cmd_wr); // R8
  AST_RAM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr |=> !ram_wr); // R8
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data != $past(wr_data)) |-> (cmd_wr || ram_wr)); // R8
  AST_EVT_GIVES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_evt |=> (cmd_wr || ram_wr)); // R9
  AST_STROBE_HAS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr || ram_wr) |-> $past(byte_evt)); // R9
endmodule

bind spi_cmd_rx spi_cmd_rx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_wr   (cmd_wr),
  .ram_wr   (ram_wr),
  .wr_data  (wr_data),
  .byte_evt (byte_evt)
);

// File: tb/spi_cmd_rx_test.sv
module spi_cmd_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic       sdi = 1'b0;
  logic       dc = 1'b0;
  logic       cmd_wr;
  logic       ram_wr;
  logic [7:0] wr_data;

  int n_chk = 0;
  int n_err = 0;
  int pulses = 0;
  int exp_pulses = 0;
  int wide = 0;
  logic prev_pulse = 1'b0;
  bit done = 1'b0;

  spi_cmd_rx uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .dc(dc),
    .cmd_wr(cmd_wr), .ram_wr(ram_wr), .wr_data(wr_data)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_wr || ram_wr) begin
        pulses++;
        if (prev_pulse) wide++;
      end
      prev_pulse = cmd_wr || ram_wr;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_latency();
    return 3; // two synchronizer edges plus the output register
  endfunction

  task automatic select(input logic v);
    repeat (3) @(negedge clk);
    cs_n = v;
    repeat (3) @(negedge clk);
  endtask

  // dc_mode: 0 random on early edges, 1 early edges opposite to final, 2 same as final
  task automatic send_byte(input logic [7:0] b, input logic d, input int dc_mode);
    int lat;
    logic [7:0] gb;
    logic gr, gc;
    for (int i = 7; i >= 0; i--) begin
      sdi = b[i];
      if (i == 0) dc = d;
      else if (dc_mode == 1) dc = ~d;
      else if (dc_mode == 2) dc = d;
      else dc = 1'($urandom % 2);
      repeat (5) @(negedge clk);
      sck = 1'b1;
      if (i == 0) begin
        lat = 0; gb = 8'h00; gr = 1'b0; gc = 1'b0;
        for (int k = 1; k <= 6; k++) begin
          @(negedge clk);
          if (lat == 0 && (cmd_wr || ram_wr)) begin
            lat = k; gb = wr_data; gr = ram_wr; gc = cmd_wr;
          end
        end
        exp_pulses++;
        check(lat == exp_latency(), "R9 strobe latency", lat, exp_latency());
        check(gb == b, "R2 byte value", gb, b);
        check(gr == d && gc == !d, "R3 R4 destination port", {gr, gc}, {d, !d});
      end else begin
        repeat (5) @(negedge clk);
      end
      sck = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = int'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    check(!cmd_wr && !ram_wr && wr_data == 8'h00, "R1 in reset", {cmd_wr, ram_wr, wr_data}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!cmd_wr && !ram_wr && wr_data == 8'h00, "R1 after reset", {cmd_wr, ram_wr, wr_data}, 0);

    // Directed: both routes, with dc opposite on early edges
    select(1'b0);
    send_byte(8'h81, 1'b1, 1);
    send_byte(8'h7E, 1'b0, 1);
    select(1'b1);

    // R5: back to back in one select period
    select(1'b0);
    send_byte(8'hA5, 1'b0, 2);
    send_byte(8'h3C, 1'b1, 2);
    send_byte(8'hFF, 1'b1, 0);
    send_byte(8'h00, 1'b0, 0);
    select(1'b1);
    check(pulses == exp_pulses, "R5 strobe count after burst", pulses, exp_pulses);

    // R6: partial byte dropped
    select(1'b0);
    for (int i = 0; i < 3; i++) begin
      sdi = 1'b1; dc = 1'b1;
      repeat (5) @(negedge clk); sck = 1'b1;
      repeat (5) @(negedge clk); sck = 1'b0;
    end
    select(1'b1);
    repeat (10) @(negedge clk);
    check(pulses == exp_pulses, "R6 no strobe for partial", pulses, exp_pulses);
    select(1'b0);
    send_byte(8'h5A, 1'b1, 0);
    select(1'b1);

    // R7: clock while deselected
    for (int i = 0; i < 12; i++) begin
      sdi = 1'b1; dc = 1'b1;
      repeat (5) @(negedge clk); sck = 1'b1;
      repeat (5) @(negedge clk); sck = 1'b0;
    end
    repeat (10) @(negedge clk);
    check(pulses == exp_pulses, "R7 no strobe while deselected", pulses, exp_pulses);
    select(1'b0);
    send_byte(8'hC3, 1'b0, 0);
    select(1'b1);

    // Random bursts
    for (int burst = 0; burst < 12; burst++) begin
      int nb;
      nb = 1 + int'($urandom % 4);
      select(1'b0);
      for (int j = 0; j < nb; j++)
        send_byte(8'($urandom), 1'($urandom % 2), 0);
      select(1'b1);
    end

    repeat (10) @(negedge clk);
    check(pulses == exp_pulses, "R8 one strobe per byte", pulses, exp_pulses);
    check(wide == 0, "R8 strobe width", wide, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule